// File: doc/BRIEF.md
# Single-Phase Fan Bridge Commutator

This block turns three control inputs into the four gate enables of a full H-bridge that drives a single-phase fan coil. The inputs are the Hall polarity decision from an external comparator, the speed-control PWM level and a lock-protection flag. The block also drives the enable of an open-drain rotation-feedback output.

While the PWM is high, the bridge pushes current through the coil in the direction set by the Hall polarity. While the PWM is low, the coil current freewheels through both low-side switches. When lock protection is raised, both high-side switches are opened. The low side of the sinking leg stays closed, so the coil terminal on that leg is held at ground.

Each polarity reversal opens both high sides for a parameterised number of cycles before the new direction is driven. A shorted leg is therefore never possible. All three inputs are registered once, and the gate enables are registered once more.

Top module: `fan_bridge_commutator`

## Requirements
- R1: With polarity 1, PWM high, lock low and no break interval running, the gates are hs_a=1, ls_b=1, ls_a=0, hs_b=0, which drives current from leg A to leg B.
- R2: With polarity 0, PWM high, lock low and no break interval running, the gates are hs_b=1, ls_a=1, hs_a=0, ls_b=0, which drives current from leg B to leg A.
- R3: With PWM low and lock low, both high sides are off and both low sides are on (freewheel).
- R4: With lock high, both high sides are off whatever the PWM level. The sinking leg keeps its low side on: ls_b=1 and ls_a=0 for polarity 1, ls_a=1 and ls_b=0 for polarity 0.
- R5: rot_en_n is 0 (pull-down active) for polarity 0 and 1 (released) for polarity 1. Lock and PWM have no effect on it.
- R6: A change of polarity starts a break of exactly DEAD_CYC output cycles. During the break both high sides are off and both low sides are on, unless lock is high, in which case R4 applies. A further change during a break restarts it.
- R7: The high side and low side of the same leg are never on together, and the two high sides are never on together.
- R8: A value on the inputs reaches the gate and rotation outputs after exactly two rising clock edges.
- R9: While reset is active, all four gate enables are 0 and rot_en_n is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| hall_pol | input | 1 | Hall comparator decision: 1 when the first Hall input is above the second |
| pwm_on | input | 1 | Speed-control PWM level: 1 means drive, 0 means freewheel |
| lock_prot | input | 1 | Lock-protection flag: 1 opens both high sides |
| hs_a | output | 1 | High-side gate enable, leg A |
| ls_a | output | 1 | Low-side gate enable, leg A |
| hs_b | output | 1 | High-side gate enable, leg B |
| ls_b | output | 1 | Low-side gate enable, leg B |
| rot_en_n | output | 1 | Active-low enable of the open-drain rotation output |

## Verification
The bench builds the block with DEAD_CYC set to 3 instead of the default 4. With the shorter break, a random stream in which the polarity flips about once every eight cycles reaches every case often: a break running to its end and handing over to drive, a break restarted by a second flip, and a break that overlaps lock. Directed sequences add a break with PWM held high throughout, lock asserted during both drive directions, and a one-cycle input change that shows the two-edge latency.

// File: rtl/fan_bridge_pkg.sv
package fan_bridge_pkg;

  typedef enum logic [1:0] {
    MODE_DRIVE = 2'd0,
    MODE_FREE  = 2'd1,
    MODE_BREAK = 2'd2,
    MODE_LOCK  = 2'd3
  } bridge_mode_e;

  typedef struct packed {
    logic hs_a;
    logic ls_a;
    logic hs_b;
    logic ls_b;
  } gate_set_t;

  localparam gate_set_t GATES_OFF = '{hs_a: 1'b0, ls_a: 1'b0, hs_b: 1'b0, ls_b: 1'b0};

endpackage

// File: rtl/fanbr_rst_sync.sv
module fanbr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_sync_n = sync_q;

endmodule

// File: rtl/fanbr_input_stage.sv
module fanbr_input_stage #(
  parameter int DEAD_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hall_pol,
  input  logic pwm_on,
  input  logic lock_prot,
  output logic pol_q,
  output logic pwm_q,
  output logic lock_q,
  output logic brk_active
);

  localparam int CW = (DEAD_CYC < 1) ? 1 : $clog2(DEAD_CYC + 1);
  localparam logic [CW-1:0] LOAD_VAL = CW'(DEAD_CYC);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          pol_flip;
  logic          cnt_en;

  always_comb begin
    pol_flip = (hall_pol != pol_q);
    cnt_en   = pol_flip || (cnt_q != '0);
    cnt_d    = cnt_q;
    if (pol_flip) begin
      cnt_d = LOAD_VAL;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pol_q  <= 1'b0;
      pwm_q  <= 1'b0;
      lock_q <= 1'b0;
    end else begin
      pol_q  <= hall_pol;
      pwm_q  <= pwm_on;
      lock_q <= lock_prot;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign brk_active = (cnt_q != '0);

  // R6: the break counter stays within its programmed length
  assert_brk_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LOAD_VAL);

  // R6: a polarity flip always arms the break for the next cycle
  assert_brk_arm_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (hall_pol != pol_q) |=> brk_active);

endmodule

// File: rtl/fanbr_mode_decode.sv
module fanbr_mode_decode
  import fan_bridge_pkg::*;
(
  input  logic         pol_q,
  input  logic         pwm_q,
  input  logic         lock_q,
  input  logic         brk_active,
  output bridge_mode_e mode,
  output gate_set_t    gates_d,
  output logic         rot_n_d
);

  always_comb begin
    if (lock_q) begin
      mode = MODE_LOCK;
    end else if (brk_active) begin
      mode = MODE_BREAK;
    end else if (!pwm_q) begin
      mode = MODE_FREE;
    end else begin
      mode = MODE_DRIVE;
    end
  end

  always_comb begin
    gates_d = GATES_OFF;
    unique case (mode)
      MODE_LOCK: begin
        gates_d.ls_a = !pol_q;
        gates_d.ls_b = pol_q;
      end
      MODE_BREAK, MODE_FREE: begin
        gates_d.ls_a = 1'b1;
        gates_d.ls_b = 1'b1;
      end
      MODE_DRIVE: begin
        gates_d.hs_a = pol_q;
        gates_d.ls_b = pol_q;
        gates_d.hs_b = !pol_q;
        gates_d.ls_a = !pol_q;
      end
      default: gates_d = GATES_OFF;
    endcase
  end

  assign rot_n_d = pol_q;

endmodule

// File: rtl/fanbr_gate_reg.sv
module fanbr_gate_reg
  import fan_bridge_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  gate_set_t gates_d,
  input  logic      rot_n_d,
  output gate_set_t gates_q,
  output logic      rot_n_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gates_q <= GATES_OFF;
      rot_n_q <= 1'b1;
    end else begin
      gates_q <= gates_d;
      rot_n_q <= rot_n_d;
    end
  end

  // R7: no leg has both switches closed
  assert_no_shoot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(gates_q.hs_a && gates_q.ls_a) && !(gates_q.hs_b && gates_q.ls_b));

  // R7: at most one high side is closed
  assert_hs_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({gates_q.hs_a, gates_q.hs_b}));

endmodule

// File: rtl/fan_bridge_commutator.sv
module fan_bridge_commutator
  import fan_bridge_pkg::*;
#(
  parameter int DEAD_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hall_pol,
  input  logic pwm_on,
  input  logic lock_prot,
  output logic hs_a,
  output logic ls_a,
  output logic hs_b,
  output logic ls_b,
  output logic rot_en_n
);

  logic         rst_sync_n;
  logic         pol_q;
  logic         pwm_q;
  logic         lock_q;
  logic         brk_active;
  bridge_mode_e mode;
  gate_set_t    gates_d;
  gate_set_t    gates_q;
  logic         rot_n_d;

  fanbr_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  fanbr_input_stage #(.DEAD_CYC(DEAD_CYC)) u_input (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .hall_pol   (hall_pol),
    .pwm_on     (pwm_on),
    .lock_prot  (lock_prot),
    .pol_q      (pol_q),
    .pwm_q      (pwm_q),
    .lock_q     (lock_q),
    .brk_active (brk_active)
  );

  fanbr_mode_decode u_decode (
    .pol_q      (pol_q),
    .pwm_q      (pwm_q),
    .lock_q     (lock_q),
    .brk_active (brk_active),
    .mode       (mode),
    .gates_d    (gates_d),
    .rot_n_d    (rot_n_d)
  );

  fanbr_gate_reg u_gates (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .gates_d (gates_d),
    .rot_n_d (rot_n_d),
    .gates_q (gates_q),
    .rot_n_q (rot_en_n)
  );

  assign hs_a = gates_q.hs_a;
  assign ls_a = gates_q.ls_a;
  assign hs_b = gates_q.hs_b;
  assign ls_b = gates_q.ls_b;

  // R4: lock opens both high sides one cycle later
  assert_lock_hs_off_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    lock_q |=> (!hs_a && !hs_b));

  // R3: freewheel closes both low sides and opens both high sides
  assert_free_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!pwm_q && !lock_q) |=> (!hs_a && !hs_b && ls_a && ls_b));

  // R6: a registered polarity change is followed by open high sides
  assert_break_hs_off_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (pol_q != $past(pol_q)) |=> (!hs_a && !hs_b));

  // R1: settled drive with polarity 1 pushes current from A to B
  assert_drive_ab_R1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (pwm_q && !lock_q && !brk_active && pol_q) |=> (hs_a && ls_b && !hs_b && !ls_a));

  // R2: settled drive with polarity 0 pushes current from B to A
  assert_drive_ba_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (pwm_q && !lock_q && !brk_active && !pol_q) |=> (hs_b && ls_a && !hs_a && !ls_b));

  // R5: rotation output follows the registered polarity only
  assert_rot_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    1'b1 |=> (rot_en_n == $past(pol_q)));

endmodule

// File: tb/fan_bridge_commutator_tb.sv
module fan_bridge_commutator_tb;

  localparam int DEAD = 3;

  logic clk;
  logic rst_n;
  logic hall_pol;
  logic pwm_on;
  logic lock_prot;
  logic hs_a, ls_a, hs_b, ls_b, rot_en_n;

  int checks;
  int errors;
  int cycles;
  bit done;

  // reference model state (stage after the input registers)
  logic       m_pol, m_pwm, m_lock;
  int         m_cnt;
  logic [4:0] exp_q;
  string      exp_tag;

  fan_bridge_commutator #(.DEAD_CYC(DEAD)) u_dut (
    .clk(clk), .rst_n(rst_n), .hall_pol(hall_pol), .pwm_on(pwm_on),
    .lock_prot(lock_prot), .hs_a(hs_a), .ls_a(ls_a), .hs_b(hs_b),
    .ls_b(ls_b), .rot_en_n(rot_en_n)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // expected {hs_a, ls_a, hs_b, ls_b, rot_en_n}
  function automatic logic [4:0] exp_out(logic pol, logic pwm, logic lck, int cnt);
    logic [3:0] g;
    if (lck)             g = {1'b0, !pol, 1'b0, pol};
    else if (cnt != 0)   g = 4'b0101;
    else if (!pwm)       g = 4'b0101;
    else if (pol)        g = 4'b1001;
    else                 g = 4'b0110;
    return {g, pol};
  endfunction

  function automatic string exp_req(logic pol, logic pwm, logic lck, int cnt);
    if (lck)           return "R4";
    else if (cnt != 0) return "R6";
    else if (!pwm)     return "R3";
    else if (pol)      return "R1";
    else               return "R2";
  endfunction

  task automatic check(string req, logic [4:0] act, logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b (hs_a ls_a hs_b ls_b rot_en_n)", req, act, exp);
    end
  endtask

  task automatic step(logic h, logic p, logic l);
    logic [4:0] act;
    @(negedge clk);
    act = {hs_a, ls_a, hs_b, ls_b, rot_en_n};
    check(exp_tag, act, exp_q);
    check("R7", {1'b0, 1'b0, (hs_a & ls_a) | (hs_b & ls_b) | (hs_a & hs_b), 2'b00}, 5'd0);
    hall_pol  = h;
    pwm_on    = p;
    lock_prot = l;
    exp_q   = exp_out(m_pol, m_pwm, m_lock, m_cnt);
    exp_tag = exp_req(m_pol, m_pwm, m_lock, m_cnt);
    if (h != m_pol)     m_cnt = DEAD;
    else if (m_cnt > 0) m_cnt = m_cnt - 1;
    m_pol  = h;
    m_pwm  = p;
    m_lock = l;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    cycles = 0;
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        errors++;
        checks++;
        $display("FAIL watchdog actual=hung expected=finished");
        finish_run();
      end
    end
  end

  initial begin
    logic h, p, l;
    checks = 0; errors = 0; done = 1'b0;
    void'($urandom(32'h5EED_0042));
    rst_n = 1'b0; hall_pol = 1'b0; pwm_on = 1'b0; lock_prot = 1'b0;
    repeat (3) @(negedge clk);
    // R9: reset state
    check("R9", {hs_a, ls_a, hs_b, ls_b, rot_en_n}, 5'b00001);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    m_pol = 1'b0; m_pwm = 1'b0; m_lock = 1'b0; m_cnt = 0;
    exp_q = exp_out(1'b0, 1'b0, 1'b0, 0);
    exp_tag = "R3";

    // R2 settled drive B to A
    repeat (4) step(1'b0, 1'b1, 1'b0);
    // R6 flip with PWM high throughout, break then R1 drive A to B
    repeat (8) step(1'b1, 1'b1, 1'b0);
    // R6 restart: flip, flip back mid-break
    step(1'b0, 1'b1, 1'b0);
    step(1'b0, 1'b1, 1'b0);
    repeat (7) step(1'b1, 1'b1, 1'b0);
    // R4 lock in both directions, PWM high; R5 rotation unaffected
    repeat (3) step(1'b1, 1'b1, 1'b1);
    repeat (6) step(1'b0, 1'b1, 1'b1);
    repeat (6) step(1'b0, 1'b1, 1'b0);
    // R8: single-cycle PWM low pulse appears two edges later for one cycle
    step(1'b0, 1'b0, 1'b0);
    repeat (4) step(1'b0, 1'b1, 1'b0);
    // R3 freewheel in both polarities
    repeat (5) step(1'b1, 1'b0, 1'b0);
    repeat (5) step(1'b0, 1'b0, 1'b0);

    // constrained random
    h = 1'b0;
    for (int i = 0; i < 3000; i++) begin
      if (($urandom % 8) == 0) h = !h;
      p = (($urandom % 4) != 0);
      l = (($urandom % 16) == 0);
      step(h, p, l);
    end
    repeat (6) step(h, 1'b1, 1'b0);
    finish_run();
  end

endmodule